// File: doc/BRIEF.md
# Chunked Memory Copy Engine

The engine executes a single copy descriptor for one channel of a DMA controller. A channel controller stages a configuration word, a byte count and source and destination addresses on the inputs, then pulses `start_i`. The engine loads these values into its own working registers. It then copies the data as a series of read-then-write request pairs on a simple memory request port. Each request carries an address, a length of 1 to 64 bytes and, for writes, the data. Each request is held until the memory acknowledges it with `mem_req_ready_i`.

The transfer is cut into chunks of a power-of-two size. The size comes from the write-size field of the configuration. All full chunks are moved first, then one shorter chunk carries any bytes that are left over. The working registers (`exec_*_o`) advance after every write, so the channel controller can watch progress. When the copy ends, the engine either leaves the final values in these registers or, in repeat mode, reloads the starting values. It reports the result as a `done_o` or `err_o` status bit.

Top module: `chunk_copy_engine`

## Requirements
- R1: A start pulse accepted with a byte count of zero sets `done_o` on the next cycle, clears `err_o`, issues no memory request, keeps `busy_o` low and leaves the working registers unchanged.
- R2: A start pulse accepted with a non-zero byte count whose read-size field (config bits 31:28) differs from its write-size field (config bits 27:24) sets `err_o` on the next cycle, clears `done_o`, issues no memory request and leaves the working registers unchanged.
- R3: The chunk length is 2 to the power of the write-size field, with the exponent capped at 6. No request is longer than 64 bytes, and none is zero bytes long.
- R4: On the cycle after an accepted start that leads to a copy, `busy_o` is high and `done_o`/`err_o` are low. `exec_cfg_o`, `exec_bytes_o`, `exec_src_o` and `exec_dst_o` then hold the staged config, count, source and destination.
- R5: Each chunk is a read request at `exec_src_o`, followed by a write request at `exec_dst_o` of the same length. The write data equals the bytes read. Full chunks come first, then one trailing request of count mod chunk bytes if that is non-zero. Afterwards the destination holds a copy of the source.
- R6: After each write acknowledge, `exec_src_o` and `exec_dst_o` grow by the request length and `exec_bytes_o` shrinks by it.
- R7: On the cycle after the last write acknowledge, `busy_o` is low and `done_o` is high. Without repeat, `exec_bytes_o` is 0.
- R8: With config bit 2 (repeat) set, the working count, source and destination read back their starting values after completion.
- R9: Config bit 3 (ordering) is carried into `exec_cfg_o` and does not change the request sequence.
- R10: A request that has not been acknowledged stays valid with unchanged address, length and direction.
- R11: A start pulse that arrives while `busy_o` is high has no effect on the status bits, the working registers or the request sequence.
- R12: After reset, `busy_o`, `done_o`, `err_o` and `mem_req_valid_o` are low and the working registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the staged descriptor |
| cfg_i | input | 32 | Staged configuration word (sizes, repeat, ordering) |
| bytes_i | input | CNT_W | Staged byte count |
| src_i | input | ADDR_W | Staged source address |
| dst_i | input | ADDR_W | Staged destination address |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Last descriptor completed |
| err_o | output | 1 | Last descriptor rejected (size mismatch) |
| exec_cfg_o | output | 32 | Working configuration |
| exec_bytes_o | output | CNT_W | Working remaining byte count |
| exec_src_o | output | ADDR_W | Working source address |
| exec_dst_o | output | ADDR_W | Working destination address |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_write_o | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr_o | output | ADDR_W | Request byte address |
| mem_req_len_o | output | MAX_LOG+1 | Request length in bytes |
| mem_req_wdata_o | output | 8<<MAX_LOG | Write data, byte i in bits 8i+7:8i |
| mem_req_ready_i | input | 1 | Request acknowledge; read data valid with it |
| mem_rdata_i | input | 8<<MAX_LOG | Read data, byte i in bits 8i+7:8i |

## Verification
A wrong sequencer state shows at the ports within one cycle. Examples are a read sent twice, a write without a read, or a request that stays valid after completion. Each one appears as a mismatch in `mem_req_write_o`, `mem_req_valid_o` or `busy_o` against the reference model. A wrong chunk length or a skipped advance of a working register shows in the next request's length or address. It is also visible at once in `exec_*_o`, since these are compared every clock. A corrupted buffer lane only appears when its write is observed: the destination copy is checked against the source when each descriptor ends.

// File: rtl/ce_pkg.sv
// Shared definitions for the chunked copy engine.
// Assumes a 32-bit configuration word whose field positions are fixed
// because the channel controller decodes the same word.
package ce_pkg;

    localparam int CFG_W          = 32;
    localparam int CFG_REPEAT_BIT = 2;
    localparam int CFG_ORDER_BIT  = 3;
    localparam int CFG_WSZ_LSB    = 24;
    localparam int CFG_RSZ_LSB    = 28;
    localparam int SZ_FLD_W       = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } ce_state_e;

endpackage

// File: rtl/ce_size_decode.sv
// Turns a log2 size field into a chunk length in bytes.
// The exponent is clamped to MAX_LOG, so the length never exceeds the
// internal buffer. Purely combinational.
module ce_size_decode #(
    parameter int MAX_LOG = 6,
    localparam int LEN_W = MAX_LOG + 1
) (
    input  logic [3:0]       size_fld,
    output logic [LEN_W-1:0] chunk_len
);
    localparam logic [3:0] CAP = 4'(MAX_LOG);

    logic [3:0] expo;

    // clamp the exponent and form the power of two
    always_comb begin
        expo      = (size_fld > CAP) ? CAP : size_fld;
        chunk_len = LEN_W'(1) << expo;
    end
endmodule

// File: rtl/ce_xfer_fsm.sv
// Request sequencer: issues one read then one write per chunk and holds
// each request until it is acknowledged.
// Assumes cur_len, last and the addresses stay stable within a chunk.
// That holds because the owner only updates them on a write acknowledge.
// Read data arrives together with the read acknowledge.
module ce_xfer_fsm
    import ce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_LOG = 6,
    localparam int LEN_W = MAX_LOG + 1,
    localparam int BUF_BYTES = 1 << MAX_LOG,
    localparam int BUF_W = 8 * BUF_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic              last,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              mem_req_ready,
    input  logic [BUF_W-1:0]  mem_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LEN_W-1:0]  mem_req_len,
    output logic [BUF_W-1:0]  mem_req_wdata,
    output logic              step,
    output logic              busy
);
    ce_state_e state_q;
    logic      rd_ack;

    assign rd_ack        = (state_q == ST_READ) && mem_req_ready;
    assign step          = (state_q == ST_WRITE) && mem_req_ready;
    assign busy          = (state_q != ST_IDLE);
    assign mem_req_valid = busy;
    assign mem_req_write = (state_q == ST_WRITE);
    assign mem_req_addr  = mem_req_write ? dst_addr : src_addr;
    assign mem_req_len   = cur_len;

    // sequence read and write phases chunk by chunk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (launch) state_q <= ST_READ;
                ST_READ:  if (mem_req_ready) state_q <= ST_WRITE;
                ST_WRITE: if (mem_req_ready) state_q <= last ? ST_IDLE : ST_READ;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_lane
        logic [7:0] byte_q;
        // capture one byte lane of read data, zero beyond the chunk length
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= 8'h00;
            end else if (rd_ack) begin
                byte_q <= (LEN_W'(g) < cur_len) ? mem_rdata[g*8 +: 8] : 8'h00;
            end
        end
        assign mem_req_wdata[g*8 +: 8] = byte_q;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_len) && $stable(mem_req_write));

    // R5
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> mem_req_valid && mem_req_write);

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_len != '0) && (mem_req_len <= LEN_W'(BUF_BYTES)));
endmodule

// File: rtl/chunk_copy_engine.sv
// Executes one copy descriptor: latches staged values into working
// registers, drives the request sequencer chunk by chunk and reports
// done or error. Assumes start_i is a single-cycle pulse from the
// channel controller. Starts while busy are dropped.
module chunk_copy_engine
    import ce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W = 32,
    parameter int MAX_LOG = 6,
    localparam int LEN_W = MAX_LOG + 1,
    localparam int BUF_W = 8 << MAX_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       cfg_i,
    input  logic [CNT_W-1:0]  bytes_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [31:0]       exec_cfg_o,
    output logic [CNT_W-1:0]  exec_bytes_o,
    output logic [ADDR_W-1:0] exec_src_o,
    output logic [ADDR_W-1:0] exec_dst_o,
    output logic              mem_req_valid_o,
    output logic              mem_req_write_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [LEN_W-1:0]  mem_req_len_o,
    output logic [BUF_W-1:0]  mem_req_wdata_o,
    input  logic              mem_req_ready_i,
    input  logic [BUF_W-1:0]  mem_rdata_i
);
    logic [CFG_W-1:0]  exec_cfg_q;
    logic [CNT_W-1:0]  exec_bytes_q, base_bytes_q;
    logic [ADDR_W-1:0] exec_src_q, exec_dst_q, base_src_q, base_dst_q;
    logic              done_q, err_q;

    logic              busy, step, last;
    logic              start_ok, zero_req, size_bad, copy_go;
    logic [LEN_W-1:0]  run_chunk, cur_len;
    logic [CNT_W-1:0]  chunk_wide;

    assign start_ok = start_i && !busy;
    assign zero_req = (bytes_i == '0);
    assign size_bad = cfg_i[CFG_RSZ_LSB +: SZ_FLD_W] != cfg_i[CFG_WSZ_LSB +: SZ_FLD_W];
    assign copy_go  = start_ok && !zero_req && !size_bad;

    ce_size_decode #(.MAX_LOG(MAX_LOG)) u_run_size (
        .size_fld  (exec_cfg_q[CFG_WSZ_LSB +: SZ_FLD_W]),
        .chunk_len (run_chunk)
    );

    // length of the current chunk: full chunk or the trailing remainder
    always_comb begin
        chunk_wide = CNT_W'(run_chunk);
        cur_len    = (exec_bytes_q >= chunk_wide) ? run_chunk : exec_bytes_q[LEN_W-1:0];
        last       = (exec_bytes_q == CNT_W'(cur_len));
    end

    ce_xfer_fsm #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (copy_go),
        .cur_len       (cur_len),
        .last          (last),
        .src_addr      (exec_src_q),
        .dst_addr      (exec_dst_q),
        .mem_req_ready (mem_req_ready_i),
        .mem_rdata     (mem_rdata_i),
        .mem_req_valid (mem_req_valid_o),
        .mem_req_write (mem_req_write_o),
        .mem_req_addr  (mem_req_addr_o),
        .mem_req_len   (mem_req_len_o),
        .mem_req_wdata (mem_req_wdata_o),
        .step          (step),
        .busy          (busy)
    );

    // load, advance and optionally restore the working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_cfg_q   <= '0;
            exec_bytes_q <= '0;
            exec_src_q   <= '0;
            exec_dst_q   <= '0;
            base_bytes_q <= '0;
            base_src_q   <= '0;
            base_dst_q   <= '0;
        end else if (copy_go) begin
            exec_cfg_q   <= cfg_i;
            exec_bytes_q <= bytes_i;
            exec_src_q   <= src_i;
            exec_dst_q   <= dst_i;
            base_bytes_q <= bytes_i;
            base_src_q   <= src_i;
            base_dst_q   <= dst_i;
        end else if (step) begin
            if (last && exec_cfg_q[CFG_REPEAT_BIT]) begin
                exec_bytes_q <= base_bytes_q;
                exec_src_q   <= base_src_q;
                exec_dst_q   <= base_dst_q;
            end else begin
                exec_bytes_q <= exec_bytes_q - CNT_W'(cur_len);
                exec_src_q   <= exec_src_q + ADDR_W'(cur_len);
                exec_dst_q   <= exec_dst_q + ADDR_W'(cur_len);
            end
        end
    end

    // completion status: cleared on accepted start, set by outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_ok) begin
            done_q <= zero_req;
            err_q  <= !zero_req && size_bad;
        end else if (step && last) begin
            done_q <= 1'b1;
        end
    end

    assign busy_o       = busy;
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign exec_cfg_o   = exec_cfg_q;
    assign exec_bytes_o = exec_bytes_q;
    assign exec_src_o   = exec_src_q;
    assign exec_dst_o   = exec_dst_q;

    // R1
    zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (bytes_i == '0) |=> done_o && !err_o && !busy_o && !mem_req_valid_o);

    // R2
    mismatch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (bytes_i != '0) && (cfg_i[31:28] != cfg_i[27:24])
            |=> err_o && !done_o && !busy_o && !mem_req_valid_o);

    // R7
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o) && !(busy_o && (done_o || err_o)));

    // R11
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(exec_cfg_o) && !done_o && !err_o);

    // R8
    repeat_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && last && exec_cfg_o[CFG_REPEAT_BIT] |=> exec_bytes_o == $past(base_bytes_q)
            && exec_src_o == $past(base_src_q) && exec_dst_o == $past(base_dst_q));
endmodule

// File: tb/sim_chunk_copy_engine.sv
`timescale 1ns / 100ps
module sim_chunk_copy_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  cfg_i = '0, bytes_i = '0, src_i = '0, dst_i = '0;
    logic         busy_o, done_o, err_o;
    logic [31:0]  exec_cfg_o, exec_bytes_o, exec_src_o, exec_dst_o;
    logic         mem_req_valid_o, mem_req_write_o;
    logic [31:0]  mem_req_addr_o;
    logic [6:0]   mem_req_len_o;
    logic [511:0] mem_req_wdata_o;
    logic         mem_req_ready_i = 1'b0;
    logic [511:0] mem_rdata_i = '0;

    chunk_copy_engine u0 (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0, run_model = 0;
    logic [7:0] mem [0:4095];

    // reference model state
    bit m_busy = 0, m_done = 0, m_err = 0, m_phase = 0;
    logic [31:0] m_cfg = '0, m_bytes = '0, m_src = '0, m_dst = '0;
    logic [31:0] b_bytes = '0, b_src = '0, b_dst = '0, m_l = '0;
    int wcnt = 0, dly = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] rs, input logic [3:0] ws,
                                       input bit rep, input bit ord);
        return {rs, ws, 20'b0, ord, rep, 2'b00};
    endfunction

    function automatic logic [31:0] len_of(input logic [31:0] cfg, input logic [31:0] left);
        int e = int'(cfg[27:24]);
        logic [31:0] c;
        if (e > 6) e = 6;
        c = 32'(1) << e;
        return (left >= c) ? c : left;
    endfunction

    // memory responder: variable acknowledge delay, read data with the ack
    always @(posedge clk) begin
        #1;
        if (mem_req_ready_i) begin
            mem_req_ready_i = 1'b0;
            wcnt = 0;
        end else if (mem_req_valid_o) begin
            if (wcnt >= dly) begin
                mem_req_ready_i = 1'b1;
                dly = (dly + 1) % 3;
                for (int i = 0; i < 64; i++)
                    mem_rdata_i[i*8 +: 8] = (i < int'(mem_req_len_o) && !mem_req_write_o)
                        ? mem[12'(mem_req_addr_o + 32'(i))] : 8'h00;
            end else begin
                wcnt++;
            end
        end
    end

    // per-clock comparison against the model, then model advance
    always @(negedge clk) begin
        if (run_model) begin
            chk(busy_o == m_busy, "R7", "busy", busy_o, m_busy);
            chk(done_o == m_done, "R1", "done", done_o, m_done);
            chk(err_o == m_err, "R2", "err", err_o, m_err);
            chk(exec_cfg_o == m_cfg, "R9", "exec_cfg", exec_cfg_o, m_cfg);
            chk(exec_bytes_o == m_bytes, "R6", "exec_bytes", exec_bytes_o, m_bytes);
            chk(exec_src_o == m_src, "R6", "exec_src", exec_src_o, m_src);
            chk(exec_dst_o == m_dst, "R6", "exec_dst", exec_dst_o, m_dst);
            chk(mem_req_valid_o == m_busy, "R5", "req_valid", mem_req_valid_o, m_busy);
            if (m_busy) begin
                m_l = len_of(m_cfg, m_bytes);
                chk(mem_req_write_o == m_phase, "R5", "req_write", mem_req_write_o, m_phase);
                chk(mem_req_addr_o == (m_phase ? m_dst : m_src), "R5", "req_addr",
                    mem_req_addr_o, m_phase ? m_dst : m_src);
                chk(32'(mem_req_len_o) == m_l, "R3", "req_len", mem_req_len_o, m_l);
            end
            if (start_i && !m_busy) begin
                m_done = 0; m_err = 0;
                if (bytes_i == 0) m_done = 1;
                else if (cfg_i[31:28] != cfg_i[27:24]) m_err = 1;
                else begin
                    m_busy = 1; m_phase = 0; m_cfg = cfg_i;
                    m_bytes = bytes_i; m_src = src_i; m_dst = dst_i;
                    b_bytes = bytes_i; b_src = src_i; b_dst = dst_i;
                end
            end else if (m_busy && mem_req_valid_o && mem_req_ready_i) begin
                if (!m_phase) begin
                    m_phase = 1;
                end else begin
                    m_l = len_of(m_cfg, m_bytes);
                    for (int i = 0; i < int'(m_l); i++)
                        mem[12'(mem_req_addr_o + 32'(i))] = mem_req_wdata_o[i*8 +: 8];
                    m_phase = 0;
                    if (m_bytes == m_l) begin
                        m_busy = 0; m_done = 1;
                        if (m_cfg[2]) begin m_bytes = b_bytes; m_src = b_src; m_dst = b_dst; end
                        else begin m_bytes = 0; m_src = m_src + m_l; m_dst = m_dst + m_l; end
                    end else begin
                        m_bytes = m_bytes - m_l; m_src = m_src + m_l; m_dst = m_dst + m_l;
                    end
                end
            end
        end
    end

    task automatic pulse(input logic [31:0] cfg, input int n, input int s, input int d);
        @(posedge clk); #1;
        cfg_i = cfg; bytes_i = 32'(n); src_i = 32'(s); dst_i = 32'(d); start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) begin @(posedge clk); #1; end
        @(posedge clk); #1;
    endtask

    task automatic copy_ok(input string req, input int n, input int s, input int d);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (mem[12'(d + i)] !== mem[12'(s + i)]) bad++;
        chk(bad == 0, req, "bytes differing after copy", bad, 0);
    endtask

    task automatic run_desc(input logic [31:0] cfg, input int n, input int s, input int d);
        pulse(cfg, n, s, d);
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 13 + 5);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!busy_o && !done_o && !err_o, "R12", "status after reset",
            {busy_o, done_o, err_o}, 0);
        chk(!mem_req_valid_o && exec_bytes_o == 0 && exec_src_o == 0 && exec_cfg_o == 0,
            "R12", "req/exec after reset", exec_bytes_o, 0);
        run_model = 1;

        // R1 zero length
        run_desc(mk(6, 6, 0, 0), 0, 'h100, 'h800);
        chk(done_o && !err_o, "R1", "done on zero count", done_o, 1);

        // R2 size mismatch
        run_desc(mk(3, 2, 0, 0), 16, 'h100, 'h800);
        chk(err_o && !done_o && exec_bytes_o == 0, "R2", "err on mismatch", err_o, 1);

        // R5 R4 small chunks with remainder
        run_desc(mk(2, 2, 0, 0), 10, 'h100, 'h800);
        chk(done_o && exec_bytes_o == 0, "R7", "done after 4,4,2", exec_bytes_o, 0);
        copy_ok("R5", 10, 'h100, 'h800);

        // R3 largest chunk, two full plus remainder
        run_desc(mk(6, 6, 0, 0), 130, 'h200, 'h900);
        chk(exec_src_o == 'h282, "R6", "src end after 130 bytes", exec_src_o, 'h282);
        copy_ok("R5", 130, 'h200, 'h900);

        // R3 size field above cap
        run_desc(mk(9, 9, 0, 0), 100, 'h300, 'hA00);
        copy_ok("R3", 100, 'h300, 'hA00);

        // R3 single-byte chunks
        run_desc(mk(0, 0, 0, 0), 3, 'h350, 'hA80);
        copy_ok("R5", 3, 'h350, 'hA80);

        // exact multiple, no remainder
        run_desc(mk(4, 4, 0, 0), 32, 'h400, 'hB00);
        chk(exec_dst_o == 'hB20, "R6", "dst end exact multiple", exec_dst_o, 'hB20);
        copy_ok("R5", 32, 'h400, 'hB00);

        // R8 repeat restores
        run_desc(mk(3, 3, 1, 0), 20, 'h500, 'hC00);
        chk(exec_bytes_o == 20 && exec_src_o == 'h500 && exec_dst_o == 'hC00, "R8",
            "repeat restore", exec_bytes_o, 20);
        chk(done_o, "R8", "done with repeat", done_o, 1);
        copy_ok("R5", 20, 'h500, 'hC00);

        // R9 ordering bit carried
        run_desc(mk(5, 5, 0, 1), 40, 'h600, 'hD00);
        chk(exec_cfg_o == mk(5, 5, 0, 1), "R9", "ordering bit in exec cfg", exec_cfg_o, mk(5, 5, 0, 1));
        copy_ok("R9", 40, 'h600, 'hD00);

        // R11 start while busy is dropped
        pulse(mk(0, 0, 0, 0), 8, 'h700, 'hE00);
        repeat (5) begin @(posedge clk); #1; end
        pulse(mk(6, 6, 0, 0), 0, 'h0, 'h0);
        chk(busy_o && !done_o, "R11", "still busy after ignored start", busy_o, 1);
        chk(exec_cfg_o == mk(0, 0, 0, 0), "R11", "exec cfg kept", exec_cfg_o, 0);
        wait_idle();
        chk(done_o && exec_src_o == 'h708, "R11", "original copy completes", exec_src_o, 'h708);
        copy_ok("R11", 8, 'h700, 'hE00);

        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog run did not end actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule